// File: doc/BRIEF.md
# Timer Compare Match Output Unit

The unit watches a free-running timer count and a stored compare value of the same width. When the two become equal, it carries out the action chosen by a 4-bit mode field. The action can toggle an output pin, force the pin high, force it low, or leave the pin alone. Every one of these actions also raises a match interrupt pulse. One further mode, the special event, leaves the pin alone. It raises the interrupt, sends a one-cycle request that clears the external timer, and sends a one-cycle conversion start to an ADC when the ADC enable input is high.

A match fires once each time the count enters equality. If the count stays at the compare value, nothing repeats. When the mode changes to force-high or force-low, the pin is first preset to the opposite level, so the match produces a visible edge. Mode codes outside the compare set do nothing. The all-zero code switches the unit off and holds the pin low. Every output is registered and changes on the clock edge at which the inputs that caused it are sampled.

The reset input is asynchronous and active low. Its release is synchronised inside the block over a parameterised number of stages.

Top module: `cmp_match_unit`

## Requirements
- R1: While reset is held, and after it is released, pin_out, match_irq, timer_clr and adc_start are all 0.
- R2: Mode 4'b0010 inverts pin_out on each match and pulses match_irq.
- R3: Mode 4'b1000 drives pin_out to 1 on a match and pulses match_irq.
- R4: Mode 4'b1001 drives pin_out to 0 on a match and pulses match_irq.
- R5: Mode 4'b1010 pulses match_irq on a match and leaves pin_out unchanged.
- R6: Mode 4'b1011 pulses match_irq and timer_clr on a match and leaves pin_out unchanged.
- R7: In mode 4'b1011, adc_start pulses together with timer_clr only if adc_en is 1 in the matching cycle.
- R8: A match is the first cycle of equality. The count holding at the compare value does not repeat the action. Entering a compare mode while the values are already equal does not fire. All outputs update at the clock edge that samples the match.
- R9: Codes 4'b0001, 4'b0011, 4'b01xx and 4'b11xx perform no action: pin_out holds, and no pulse is produced.
- R10: Code 4'b0000 drives pin_out to 0 and performs no match action.
- R11: A mode change into 4'b1000 presets pin_out to 0, and a change into 4'b1001 presets it to 1. A match in the same cycle overrides the preset.
- R12: match_irq, timer_clr and adc_start are single-cycle pulses. timer_clr and adc_start occur only in mode 4'b1011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_val | input | TIMER_W | Current timer count |
| cmp_val | input | TIMER_W | Compare value |
| mode_sel | input | 4 | Action selector |
| adc_en | input | 1 | Allows the ADC start pulse |
| pin_out | output | 1 | Compare output pin |
| match_irq | output | 1 | Match interrupt pulse |
| timer_clr | output | 1 | Timer clear request pulse |
| adc_start | output | 1 | ADC conversion start pulse |

## Verification
The bench sweeps the count through each boundary compare value (0, 1, 0x8000, 0xFFFF), including the wrap from 0xFFFF to 0. It holds the count at the compare value for a second cycle. A comparator that fires on level rather than on entry would toggle twice there or pulse the interrupt repeatedly. A slice comparator that drops a bit would fire at the wrong count. The bench enters the toggle mode while the values are already equal, which a design without a running equality history would treat as a match. It switches into force-high and force-low with and without a simultaneous match, exposing a missing preset or a preset that wrongly beats the match. It runs every non-compare code, which would catch a decoder that aliases reserved codes onto actions. It runs the special event with adc_en both low and high, catching an ungated or stretched start pulse.

// File: rtl/cmp_match_pkg.sv
package cmp_match_pkg;

  localparam logic [3:0] MODE_OFF    = 4'b0000;
  localparam logic [3:0] MODE_TOGGLE = 4'b0010;
  localparam logic [3:0] MODE_SET    = 4'b1000;
  localparam logic [3:0] MODE_CLEAR  = 4'b1001;
  localparam logic [3:0] MODE_FLAG   = 4'b1010;
  localparam logic [3:0] MODE_EVENT  = 4'b1011;

  typedef enum logic [2:0] {
    ACT_NONE   = 3'd0,
    ACT_TOGGLE = 3'd1,
    ACT_SET    = 3'd2,
    ACT_CLEAR  = 3'd3,
    ACT_FLAG   = 3'd4,
    ACT_EVENT  = 3'd5
  } cm_act_e;

  function automatic cm_act_e cm_decode(input logic [3:0] m);
    cm_act_e a;
    case (m)
      MODE_TOGGLE: a = ACT_TOGGLE;
      MODE_SET:    a = ACT_SET;
      MODE_CLEAR:  a = ACT_CLEAR;
      MODE_FLAG:   a = ACT_FLAG;
      MODE_EVENT:  a = ACT_EVENT;
      default:     a = ACT_NONE;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/cmp_rst_sync.sv
module cmp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/cmp_eq_detect.sv
module cmp_eq_detect #(
  parameter int W     = 16,
  parameter int SLICE = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq_now,
  output logic         eq_entry
);

  localparam int NSL = (W + SLICE - 1) / SLICE;
  localparam int PW  = NSL * SLICE;

  logic [PW-1:0]  a_p;
  logic [PW-1:0]  b_p;
  logic [NSL-1:0] slice_eq;
  logic           eq_q;
  logic           eq_d;

  always_comb begin
    a_p = '0;
    b_p = '0;
    a_p[W-1:0] = a;
    b_p[W-1:0] = b;
  end

  for (genvar i = 0; i < NSL; i++) begin : g_slice
    assign slice_eq[i] = (a_p[i*SLICE +: SLICE] == b_p[i*SLICE +: SLICE]);
  end

  assign eq_now   = &slice_eq;
  assign eq_entry = eq_now & ~eq_q;

  always_comb begin
    eq_d = eq_now;
  end

  // Reset to "already equal" so a value sitting at the compare point at
  // reset release is not treated as a fresh match.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b1;
    else        eq_q <= eq_d;
  end

endmodule

// File: rtl/cmp_mode_track.sv
module cmp_mode_track
  import cmp_match_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode_sel,
  output cm_act_e    act,
  output logic       off,
  output logic       preset_lo,
  output logic       preset_hi
);

  logic [3:0] mode_q;
  logic       mode_chg;
  logic       mode_en;

  assign act      = cm_decode(mode_sel);
  assign off      = (mode_sel == MODE_OFF);
  assign mode_chg = (mode_sel != mode_q);
  assign mode_en  = mode_chg;

  assign preset_lo = mode_chg & (act == ACT_SET);
  assign preset_hi = mode_chg & (act == ACT_CLEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_OFF;
    else if (mode_en) mode_q <= mode_sel;
  end

endmodule

// File: rtl/cmp_out_stage.sv
module cmp_out_stage
  import cmp_match_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  cm_act_e act,
  input  logic    off,
  input  logic    preset_lo,
  input  logic    preset_hi,
  input  logic    hit,
  input  logic    adc_en,
  output logic    pin_out,
  output logic    match_irq,
  output logic    timer_clr,
  output logic    adc_start
);

  logic pin_q, pin_d, pin_en;
  logic irq_q, irq_d;
  logic clr_q, clr_d;
  logic adc_q, adc_d;
  logic act_hit;

  assign act_hit = hit & (act != ACT_NONE) & ~off;

  always_comb begin
    pin_d  = pin_q;
    pin_en = 1'b0;
    if (off) begin
      pin_d  = 1'b0;
      pin_en = 1'b1;
    end else if (act_hit && act == ACT_TOGGLE) begin
      pin_d  = ~pin_q;
      pin_en = 1'b1;
    end else if (act_hit && act == ACT_SET) begin
      pin_d  = 1'b1;
      pin_en = 1'b1;
    end else if (act_hit && act == ACT_CLEAR) begin
      pin_d  = 1'b0;
      pin_en = 1'b1;
    end else if (preset_lo) begin
      pin_d  = 1'b0;
      pin_en = 1'b1;
    end else if (preset_hi) begin
      pin_d  = 1'b1;
      pin_en = 1'b1;
    end
  end

  always_comb begin
    irq_d = act_hit;
    clr_d = act_hit & (act == ACT_EVENT);
    adc_d = act_hit & (act == ACT_EVENT) & adc_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_q <= 1'b0;
    else if (pin_en) pin_q <= pin_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      clr_q <= 1'b0;
      adc_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      clr_q <= clr_d;
      adc_q <= adc_d;
    end
  end

  assign pin_out   = pin_q;
  assign match_irq = irq_q;
  assign timer_clr = clr_q;
  assign adc_start = adc_q;

endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit
  import cmp_match_pkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int CMP_SLICE   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TIMER_W-1:0] timer_val,
  input  logic [TIMER_W-1:0] cmp_val,
  input  logic [3:0]         mode_sel,
  input  logic               adc_en,
  output logic               pin_out,
  output logic               match_irq,
  output logic               timer_clr,
  output logic               adc_start
);

  logic    rst_sync_n;
  logic    eq_now;
  logic    eq_entry;
  cm_act_e act;
  logic    off;
  logic    preset_lo;
  logic    preset_hi;
  logic    eq_unused;

  assign eq_unused = eq_now;

  cmp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cmp_eq_detect #(.W(TIMER_W), .SLICE(CMP_SLICE)) u_eq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .a        (timer_val),
    .b        (cmp_val),
    .eq_now   (eq_now),
    .eq_entry (eq_entry)
  );

  cmp_mode_track u_mode (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mode_sel  (mode_sel),
    .act       (act),
    .off       (off),
    .preset_lo (preset_lo),
    .preset_hi (preset_hi)
  );

  cmp_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .act       (act),
    .off       (off),
    .preset_lo (preset_lo),
    .preset_hi (preset_hi),
    .hit       (eq_entry),
    .adc_en    (adc_en),
    .pin_out   (pin_out),
    .match_irq (match_irq),
    .timer_clr (timer_clr),
    .adc_start (adc_start)
  );

endmodule

// File: rtl/cmp_match_chk.sv
module cmp_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] mode_sel,
  input logic       pin_out,
  input logic       match_irq,
  input logic       timer_clr,
  input logic       adc_start
);

  // R12
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |=> !match_irq);

  // R12
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer_clr |=> !timer_clr);

  // R7
  adc_with_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> timer_clr);

  // R6
  clr_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer_clr |-> match_irq);

  // R3
  set_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_irq && $past(mode_sel) == 4'b1000) |-> pin_out);

  // R4
  clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_irq && $past(mode_sel) == 4'b1001) |-> !pin_out);

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_irq && $past(mode_sel) == 4'b1010) |-> $stable(pin_out));

  // R10
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_sel) == 4'b0000) |-> (!pin_out && !match_irq));

endmodule

bind cmp_match_unit cmp_match_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .mode_sel  (mode_sel),
  .pin_out   (pin_out),
  .match_irq (match_irq),
  .timer_clr (timer_clr),
  .adc_start (adc_start)
);

// File: tb/cmp_match_unit_tb_top.sv
`timescale 1ns/1ps
module cmp_match_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] timer_val;
  logic [15:0] cmp_val;
  logic [3:0]  mode_sel;
  logic        adc_en;
  logic        pin_out, match_irq, timer_clr, adc_start;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cmp_match_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .timer_val (timer_val),
    .cmp_val   (cmp_val),
    .mode_sel  (mode_sel),
    .adc_en    (adc_en),
    .pin_out   (pin_out),
    .match_irq (match_irq),
    .timer_clr (timer_clr),
    .adc_start (adc_start)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive away from the edge, then sample just after the next rising edge.
  task automatic apply(input logic [15:0] t, input logic [15:0] c,
                       input logic [3:0] m, input logic e);
    @(negedge clk);
    timer_val = t;
    cmp_val   = c;
    mode_sel  = m;
    adc_en    = e;
    @(posedge clk);
    #1;
  endtask

  task automatic check_outs(input string tag, input logic p, input logic i,
                            input logic c, input logic a);
    chk({tag, " pin"}, {31'd0, pin_out}, {31'd0, p});
    chk({tag, " irq"}, {31'd0, match_irq}, {31'd0, i});
    chk({tag, " clr"}, {31'd0, timer_clr}, {31'd0, c});
    chk({tag, " adc"}, {31'd0, adc_start}, {31'd0, a});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic exp_pin;
    logic [15:0] prev_t;
    logic [15:0] bnd [4];
    int offs [5];
    rst_n = 1'b0;
    timer_val = 16'h0000;
    cmp_val = 16'h0000;
    mode_sel = 4'b0000;
    adc_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_outs("R1 in reset", 0, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check_outs("R1 after release", 0, 0, 0, 0);

    // R8: enter toggle mode while already equal -> no action
    apply(16'h0042, 16'h0042, 4'b0000, 0);
    apply(16'h0042, 16'h0042, 4'b0010, 0);
    check_outs("R8 enter while equal", 0, 0, 0, 0);

    // R2 / R8: boundary sweep in toggle mode, including hold at the match value
    bnd[0] = 16'h0000; bnd[1] = 16'h0001; bnd[2] = 16'h8000; bnd[3] = 16'hFFFF;
    offs[0] = -2; offs[1] = -1; offs[2] = 0; offs[3] = 0; offs[4] = 1;
    exp_pin = 1'b0;
    for (int b = 0; b < 4; b++) begin
      prev_t = bnd[b] + 16'd7;
      apply(prev_t, bnd[b], 4'b0010, 0);
      check_outs("R2 idle", exp_pin, 0, 0, 0);
      for (int k = 0; k < 5; k++) begin
        logic [15:0] t;
        logic exp_irq;
        t = bnd[b] + 16'(offs[k]);
        exp_irq = (t == bnd[b]) && (prev_t != bnd[b]);
        apply(t, bnd[b], 4'b0010, 0);
        if (exp_irq) exp_pin = ~exp_pin;
        check_outs("R2 R8 sweep", exp_pin, exp_irq, 0, 0);
        prev_t = t;
      end
    end
    // exp_pin is 0 after four toggles

    // R2: toggle from 1 back to 0 with a fresh value
    apply(16'h1233, 16'h1234, 4'b0010, 0);
    apply(16'h1234, 16'h1234, 4'b0010, 0);
    check_outs("R2 toggle up", 1, 1, 0, 0);
    apply(16'h1235, 16'h1234, 4'b0010, 0);
    apply(16'h1234, 16'h1234, 4'b0010, 0);
    check_outs("R2 toggle down", 0, 1, 0, 0);
    apply(16'h1235, 16'h1234, 4'b0010, 0);

    // R11: change into set mode presets low; R3: match drives high
    apply(16'h1235, 16'h1234, 4'b1000, 0);
    check_outs("R11 preset low", 0, 0, 0, 0);
    apply(16'h1234, 16'h1234, 4'b1000, 0);
    check_outs("R3 set high", 1, 1, 0, 0);
    apply(16'h1000, 16'h1234, 4'b1000, 0);
    check_outs("R12 irq single", 1, 0, 0, 0);

    // R11: change into clear mode presets high; R4: match drives low
    apply(16'h1000, 16'h1234, 4'b0010, 0);
    apply(16'h1000, 16'h1234, 4'b0000, 0);
    check_outs("R10 off low", 0, 0, 0, 0);
    apply(16'h1000, 16'h1234, 4'b1001, 0);
    check_outs("R11 preset high", 1, 0, 0, 0);
    apply(16'h1234, 16'h1234, 4'b1001, 0);
    check_outs("R4 clear low", 0, 1, 0, 0);
    apply(16'h1000, 16'h1234, 4'b1001, 0);

    // R11: match in the same cycle as the change into set mode wins
    apply(16'h1234, 16'h1234, 4'b1000, 0);
    check_outs("R11 match beats preset", 1, 1, 0, 0);
    apply(16'h1000, 16'h1234, 4'b1000, 0);

    // R5: flag-only mode keeps the pin
    apply(16'h1000, 16'h1234, 4'b1010, 0);
    apply(16'h1234, 16'h1234, 4'b1010, 0);
    check_outs("R5 flag only", 1, 1, 0, 0);
    apply(16'h1000, 16'h1234, 4'b1010, 1);

    // R6 / R7: special event without and with ADC enable
    apply(16'h1000, 16'h1234, 4'b1011, 0);
    apply(16'h1234, 16'h1234, 4'b1011, 0);
    check_outs("R6 R7 event adc off", 1, 1, 1, 0);
    apply(16'h1234, 16'h1234, 4'b1011, 1);
    check_outs("R8 R12 event hold", 1, 0, 0, 0);
    apply(16'h0000, 16'h1234, 4'b1011, 1);
    apply(16'h1234, 16'h1234, 4'b1011, 1);
    check_outs("R7 event adc on", 1, 1, 1, 1);
    apply(16'h0000, 16'h1234, 4'b1011, 1);
    check_outs("R12 event single", 1, 0, 0, 0);

    // R9: all non-compare codes, with the pin at 1 and then at 0
    for (int p = 0; p < 2; p++) begin
      logic hold;
      hold = (p == 0);
      if (!hold) begin
        apply(16'h0000, 16'h1234, 4'b0000, 0);
      end
      for (int m = 1; m < 16; m++) begin
        logic [3:0] mc;
        mc = 4'(m);
        if (mc == 4'b0010 || mc[3:2] == 2'b10) continue;
        apply(16'h0000, 16'h1234, mc, 1);
        check_outs("R9 idle", hold, 0, 0, 0);
        apply(16'h1234, 16'h1234, mc, 1);
        check_outs("R9 no action", hold, 0, 0, 0);
      end
    end

    // R10: off mode ignores a match
    apply(16'h0000, 16'h1234, 4'b0000, 1);
    apply(16'h1234, 16'h1234, 4'b0000, 1);
    check_outs("R10 off match", 0, 0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule